// File: doc/BRIEF.md
# Split-Word Interrupt Controller with Vector

The controller gathers 64 interrupt inputs into two 32-bit state words, called high and low, and drives a single interrupt line to the processor. Each source has a 2-bit sense setting: level low, level high, falling edge or rising edge. Level-sensed sources show the current input level in their pending bit. Edge-sensed sources latch a detected edge and hold it until software clears it. A per-source enable bit, kept in a mask word, decides whether a pending source can reach the output line and the vector.

Source numbers do not map to bit positions by simple arithmetic. A fixed permutation places every source at one bit of either the high or the low word. The mask and pending registers use the same placement. A vector register gives software the lowest-numbered active source in its top six bits, with zero meaning nothing is active. Source 0 has a bit position but is reserved: it never drives the output line and never appears in the vector.

Software reaches the block through a simple register port. Reads are combinational and have no side effects. A write takes effect at the next clock edge.

Top module: `split_word_intc`

## Requirements
- R1: After reset both mask words read 0, both pending words read 0 while all inputs are low, the vector reads 0, irq_o is 0, and every sense register reads 32'h5555_5555, which sets every source to level high.
- R2: Source placement is as follows. Source 0 is at high bit 0. Sources 1..15 are at high bit 16-s. Sources 16..31 are at low bit 31-s. Sources 32..47 are at high bit 63-s. Sources 48..63 are at low bit s-32. Mask and pending registers both use this placement.
- R3: A mask bit of 1 enables its source. A source whose mask bit is 0 affects neither irq_o nor the vector, but its pending bit still reads back.
- R4: Writing the pending register of a word (address 2 for high, 3 for low) clears each edge-latched pending bit whose data bit is 1. Data bits of 0 leave the pending bits unchanged.
- R5: With sense code 0 (level low) or 1 (level high), the pending bit equals whether the input was at its active level at the previous clock edge. A write-one-to-clear does not hold it low.
- R6: With sense code 2 (falling) or 3 (rising), the pending bit sets one cycle after the sampled input makes that transition and stays set until cleared. If a new edge and a clear arrive in the same cycle, the bit stays set.
- R7: The vector register (address 4) holds, in bits 31:26, the lowest source number in 1..63 that is both pending and enabled, or 0 if there is none. Bits 25:0 read 0.
- R8: irq_o is 1 exactly when some source in 1..63 is both pending and enabled. Source 0 never asserts irq_o.
- R9: The register map is: 0 high mask, 1 low mask, 2 high pending, 3 low pending, 4 vector, 5..8 sense for sources 0-15, 16-31, 32-47, 48-63 (source s%16 in bits 2*(s%16)+1:2*(s%16)). Reads have no side effects. Other addresses read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Interrupt inputs, synchronous to clk_i, indexed by source number |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A wrong entry in the placement permutation shows on the next read of a pending word after one source is pulsed: the bit appears in the wrong place or in the wrong word. A stuck or dropped edge latch shows one cycle after the edge, or on the first read after a clear. A faulty priority encoder or mask gate shows as a wrong vector or a wrong irq_o in the same cycle the pending state settles. The random phase compares every pending word, the vector and irq_o against a bench model on every cycle, so any divergence is reported within one clock.

// File: rtl/swic_pkg.sv
package swic_pkg;
  localparam int WORD_W  = 32;
  localparam int NUM_SRC = 2 * WORD_W;
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int GRP_SZ  = WORD_W / 2;   // sources per sense register
  localparam int NUM_GRP = NUM_SRC / GRP_SZ;

  typedef enum logic [1:0] {
    SENSE_LVL_LO = 2'd0,
    SENSE_LVL_HI = 2'd1,
    SENSE_FALL   = 2'd2,
    SENSE_RISE   = 2'd3
  } sense_e;

  localparam logic [3:0] A_MASK_HI = 4'd0;
  localparam logic [3:0] A_MASK_LO = 4'd1;
  localparam logic [3:0] A_PEND_HI = 4'd2;
  localparam logic [3:0] A_PEND_LO = 4'd3;
  localparam logic [3:0] A_VEC     = 4'd4;
  localparam logic [3:0] A_SENSE0  = 4'd5;

  function automatic bit src_in_hi(int s);
    return (s < 16) || (s >= 32 && s < 48);
  endfunction

  function automatic int src_bit(int s);
    if (s == 0)      return 0;
    else if (s < 16) return 16 - s;
    else if (s < 32) return 31 - s;
    else if (s < 48) return 63 - s;
    else             return s - 32;
  endfunction
endpackage

// File: rtl/swic_src_cell.sv
module swic_src_cell
  import swic_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   in_i,
  input  sense_e sense_i,
  input  logic   clr_i,
  output logic   pend_o
);
  logic prev_q, pend_q, pend_d;

  always_comb begin
    unique case (sense_i)
      SENSE_LVL_LO: pend_d = ~in_i;
      SENSE_LVL_HI: pend_d = in_i;
      SENSE_FALL:   pend_d = (pend_q & ~clr_i) | (prev_q & ~in_i);
      default:      pend_d = (pend_q & ~clr_i) | (~prev_q & in_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= in_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/swic_prio.sv
module swic_prio #(
  parameter int N = 64,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic [W-1:0] idx_o
);
  // lowest index wins; index 0 doubles as "none"
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 1; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/split_word_intc.sv
module split_word_intc
  import swic_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [WORD_W-1:0]   rdata_o,
  output logic                irq_o
);
  localparam logic [WORD_W-1:0] SENSE_RST = {GRP_SZ{2'b01}};

  logic [WORD_W-1:0]              mask_hi_q, mask_lo_q;
  logic [NUM_GRP-1:0][WORD_W-1:0] sense_q;
  logic [NUM_SRC-1:0]             pend_src, en_src, clr_src, req_src;
  logic [WORD_W-1:0]              pend_hi_w, pend_lo_w;
  logic [SRC_W-1:0]               vec_id;

  logic wr_pend_hi, wr_pend_lo;
  assign wr_pend_hi = we_i && (addr_i == ADDR_W'(A_PEND_HI));
  assign wr_pend_lo = we_i && (addr_i == ADDR_W'(A_PEND_LO));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int B = src_bit(s);
    localparam int G = s / GRP_SZ;
    localparam int F = 2 * (s % GRP_SZ);
    if (src_in_hi(s)) begin : g_hi
      assign en_src[s]    = mask_hi_q[B];
      assign clr_src[s]   = wr_pend_hi & wdata_i[B];
      assign pend_hi_w[B] = pend_src[s];
    end else begin : g_lo
      assign en_src[s]    = mask_lo_q[B];
      assign clr_src[s]   = wr_pend_lo & wdata_i[B];
      assign pend_lo_w[B] = pend_src[s];
    end
    swic_src_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .in_i    (src_i[s]),
      .sense_i (sense_e'(sense_q[G][F+:2])),
      .clr_i   (clr_src[s]),
      .pend_o  (pend_src[s])
    );
  end

  // source 0 is reserved: it never reaches the line or the vector
  assign req_src = {pend_src[NUM_SRC-1:1] & en_src[NUM_SRC-1:1], 1'b0};
  assign irq_o   = |req_src;

  swic_prio #(.N(NUM_SRC)) u_prio (
    .req_i (req_src),
    .idx_o (vec_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_hi_q <= '0;
      mask_lo_q <= '0;
      sense_q   <= {NUM_GRP{SENSE_RST}};
    end else if (we_i) begin
      if (addr_i == ADDR_W'(A_MASK_HI)) mask_hi_q <= wdata_i;
      if (addr_i == ADDR_W'(A_MASK_LO)) mask_lo_q <= wdata_i;
      for (int g = 0; g < NUM_GRP; g++) begin
        if (addr_i == ADDR_W'(A_SENSE0) + ADDR_W'(g)) sense_q[g] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if      (addr_i == ADDR_W'(A_MASK_HI)) rdata_o = mask_hi_q;
    else if (addr_i == ADDR_W'(A_MASK_LO)) rdata_o = mask_lo_q;
    else if (addr_i == ADDR_W'(A_PEND_HI)) rdata_o = pend_hi_w;
    else if (addr_i == ADDR_W'(A_PEND_LO)) rdata_o = pend_lo_w;
    else if (addr_i == ADDR_W'(A_VEC))     rdata_o = {vec_id, {(WORD_W-SRC_W){1'b0}}};
    else begin
      for (int g = 0; g < NUM_GRP; g++) begin
        if (addr_i == ADDR_W'(A_SENSE0) + ADDR_W'(g)) rdata_o = sense_q[g];
      end
    end
  end
endmodule

// File: rtl/split_word_intc_chk.sv
module split_word_intc_chk
  import swic_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic               irq_o,
  input logic [SRC_W-1:0]   vec_id,
  input logic [WORD_W-1:0]  mask_hi_q,
  input logic [WORD_W-1:0]  mask_lo_q,
  input logic [NUM_SRC-1:0] pend_src,
  input logic [NUM_SRC-1:0] en_src
);
  // R8
  line_matches_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (vec_id != '0));

  // R7
  vec_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_id != '0) |-> (pend_src[vec_id] && en_src[vec_id]));

  // R3
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_hi_q == '0 && mask_lo_q == '0) |-> (!irq_o && vec_id == '0));

  // R9
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(mask_hi_q) && $stable(mask_lo_q)));
endmodule

bind split_word_intc split_word_intc_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .irq_o     (irq_o),
  .vec_id    (vec_id),
  .mask_hi_q (mask_hi_q),
  .mask_lo_q (mask_lo_q),
  .pend_src  (pend_src),
  .en_src    (en_src)
);

// File: tb/split_word_intc_tb.sv
module split_word_intc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  split_word_intc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic bit tb_hi(int s);
    return ((s / 16) % 2) == 0;
  endfunction
  function automatic int tb_bit(int s);
    case (s / 16)
      0:       return (s == 0) ? 0 : 16 - s;
      1:       return 31 - s;
      2:       return 63 - s;
      default: return s - 32;
    endcase
  endfunction

  // reference model
  logic [63:0]     m_pend, m_prev;
  logic [31:0]     m_mhi, m_mlo;
  logic [3:0][31:0] m_sense;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= '0; m_prev <= '0; m_mhi <= '0; m_mlo <= '0;
      m_sense <= {4{32'h5555_5555}};
    end else begin
      for (int s = 0; s < 64; s++) begin
        logic [1:0] c;
        logic clr;
        c = m_sense[s/16][2*(s%16)+:2];
        clr = we && (addr == (tb_hi(s) ? 4'd2 : 4'd3)) && wdata[tb_bit(s)];
        case (c)
          2'd0: m_pend[s] <= !src[s];
          2'd1: m_pend[s] <= src[s];
          2'd2: m_pend[s] <= (m_pend[s] && !clr) || (m_prev[s] && !src[s]);
          default: m_pend[s] <= (m_pend[s] && !clr) || (!m_prev[s] && src[s]);
        endcase
      end
      m_prev <= src;
      if (we) begin
        if (addr == 4'd0) m_mhi <= wdata;
        if (addr == 4'd1) m_mlo <= wdata;
        if (addr >= 4'd5 && addr <= 4'd8) m_sense[addr-4'd5] <= wdata;
      end
    end
  end

  function automatic logic [31:0] exp_word(bit hi);
    logic [31:0] w = '0;
    for (int s = 0; s < 64; s++) if (tb_hi(s) == hi) w[tb_bit(s)] = m_pend[s];
    return w;
  endfunction
  function automatic int exp_vec();
    for (int s = 1; s < 64; s++) begin
      logic en;
      en = tb_hi(s) ? m_mhi[tb_bit(s)] : m_mlo[tb_bit(s)];
      if (m_pend[s] && en) return s;
    end
    return 0;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d; step(); we = 1'b0;
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    int v;
    v = exp_vec();
    rd(4'd2, d); chk({tag, " R2 pend_hi"}, d, exp_word(1'b1));
    rd(4'd3, d); chk({tag, " R4 pend_lo"}, d, exp_word(1'b0));
    rd(4'd4, d); chk({tag, " R7 vector"}, d, {v[5:0], 26'd0});
    chk({tag, " R8 irq"}, {31'd0, irq}, {31'd0, v != 0});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int list [10] = '{0, 1, 15, 16, 31, 32, 47, 48, 63, 9};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, d); chk("R1 mask_hi", d, 32'h0);
    rd(4'd1, d); chk("R1 mask_lo", d, 32'h0);
    rd(4'd2, d); chk("R1 pend_hi", d, 32'h0);
    rd(4'd4, d); chk("R1 vector", d, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    for (int g = 0; g < 4; g++) begin
      rd(4'(5 + g), d); chk("R1 sense", d, 32'h5555_5555);
    end

    // all rising edge, all enabled
    for (int g = 0; g < 4; g++) wr(4'(5 + g), 32'hFFFF_FFFF);
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd1, 32'hFFFF_FFFF);

    // R2 placement, one source at a time
    foreach (list[i]) begin
      int s;
      logic [31:0] e;
      s = list[i];
      src[s] = 1'b1; step();
      e = 32'd1 << tb_bit(s);
      rd(4'd2, d); chk("R2 hi word", d, tb_hi(s) ? e : 32'd0);
      rd(4'd3, d); chk("R2 lo word", d, tb_hi(s) ? 32'd0 : e);
      rd(4'd4, d); chk("R7 single vector", d, {6'(s), 26'd0});
      chk("R8 single irq", {31'd0, irq}, {31'd0, s != 0});
      if (s == 1)  begin rd(4'd2, d); chk("R2 src1 literal", d, 32'h0000_8000); end
      if (s == 32) begin rd(4'd2, d); chk("R2 src32 literal", d, 32'h8000_0000); end
      if (s == 48) begin rd(4'd3, d); chk("R2 src48 literal", d, 32'h0001_0000); end
      if (s == 31) begin rd(4'd3, d); chk("R2 src31 literal", d, 32'h0000_0001); end
      src[s] = 1'b0;
      wr(4'd2, 32'hFFFF_FFFF);
      wr(4'd3, 32'hFFFF_FFFF);
    end

    // R4 write zero keeps, write one clears (source 5 at high bit 11)
    src[5] = 1'b1; step(); src[5] = 1'b0;
    wr(4'd2, 32'h0);
    rd(4'd2, d); chk("R4 write0 keeps", d, 32'h0000_0800);
    wr(4'd2, 32'h0000_0800);
    rd(4'd2, d); chk("R4 write1 clears", d, 32'h0);

    // R6 edge and clear in the same cycle: set wins
    src[5] = 1'b1; wr(4'd2, 32'h0000_0800);
    rd(4'd2, d); chk("R6 set beats clear", d, 32'h0000_0800);
    wr(4'd2, 32'h0000_0800); src[5] = 1'b0; step();
    // R6 falling edge (sense code 2) for source 5
    wr(4'd5, 32'hFFFF_FBFF);
    src[5] = 1'b1; step();
    rd(4'd2, d); chk("R6 no fall yet", d, 32'h0);
    src[5] = 1'b0; step();
    rd(4'd2, d); chk("R6 falling latched", d, 32'h0000_0800);
    wr(4'd2, 32'h0000_0800);

    // R5 level high on source 7 (high bit 9)
    wr(4'd5, 32'h5555_5555);
    src[7] = 1'b1; step();
    rd(4'd2, d); chk("R5 level set", d, 32'h0000_0200);
    wr(4'd2, 32'h0000_0200);
    rd(4'd2, d); chk("R5 clear no effect", d, 32'h0000_0200);
    // R7 priority: 40 and 7 both active -> 7
    wr(4'd7, 32'h5555_5555);
    src[40] = 1'b1; step();
    rd(4'd4, d); chk("R7 lowest wins", d, {6'd7, 26'd0});
    // R3 mask 7 off -> vector 40
    wr(4'd0, 32'hFFFF_FDFF);
    rd(4'd4, d); chk("R3 masked skipped", d, {6'd40, 26'd0});
    wr(4'd0, 32'h0);
    rd(4'd4, d); chk("R3 all masked vec", d, 32'h0);
    chk("R3 all masked irq", {31'd0, irq}, 32'd0);
    rd(4'd2, d); chk("R3 pend still visible", d, 32'h0080_0200);
    src[7] = 1'b0; src[40] = 1'b0;

    // R9 unmapped address, reads without side effect
    wr(4'd12, 32'hFFFF_FFFF);
    rd(4'd12, d); chk("R9 unmapped reads 0", d, 32'h0);
    rd(4'd0, d); chk("R9 mask untouched", d, 32'h0);
    rd(4'd4, d); rd(4'd4, d); chk("R9 vector reread", d, 32'h0);

    // random phase against model
    for (int n = 0; n < 3000; n++) begin
      int r;
      src = {$urandom, $urandom};
      r = $urandom_range(0, 9);
      we = (r < 5);
      case (r)
        0: begin addr = 4'd2; wdata = $urandom; end
        1: begin addr = 4'd3; wdata = $urandom; end
        2: begin addr = 4'd0; wdata = $urandom; end
        3: begin addr = 4'd1; wdata = $urandom; end
        4: begin addr = 4'($urandom_range(5, 15)); wdata = $urandom; end
        default: addr = 4'd0;
      endcase
      step();
      we = 1'b0;
      check_all("rand R5 R6");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule